// File: doc/BRIEF.md
# Synchronous Host-Bus Slave Bridge

This block is a slave on a synchronous 8-bit host bus that uses a transfer-start strobe and a transfer-acknowledge reply. When the host selects the block and starts a transfer, the bridge latches the 5-bit address and the direction. On the next edge it captures write data. Address bit 4 then steers the access to one of two places: a simple internal register port, serviced in one cycle, or user logic, reached through a start/end handshake. The bridge holds the host in wait states until the target completes. It then acknowledges for exactly one clock and pulses burst-inhibit with that acknowledge. On reads it enables the external data drivers only during the acknowledge cycle.

A timeout counter guards the user handshake. If user logic never returns its end signal, the bridge still acknowledges the host. Reads then return 0xFF, and a sticky flag records the event. A level-sensitive, active-low interrupt from user logic passes through a two-flop synchronizer to the host interrupt pin and to a pending status output. Transfers have no effect on this path.

The controller has six states. IDLE leaves on a selected transfer start (*start*) to CAPTURE. CAPTURE goes to INTERNAL when address bit 4 is 0 (*to_reg*) or to USTART when it is 1 (*to_user*). INTERNAL always goes to ACK (*reg_done*). USTART and UWAIT go to ACK on user end or timer expiry (*user_done*). Otherwise they move to or stay in UWAIT (*wait*). ACK always returns to IDLE (*release*).

Top module: `host_bus_bridge`

## Requirements
- R1: A transfer is accepted only when `cs_lo_n` is 0 and `cs_hi` is 1 in the cycle where `tstart_n` is sampled 0. Any other chip-select combination leaves `ack_n` high and produces no register or user strobe.
- R2: With address bit 4 = 0, the access goes to the register port. `reg_addr` equals address bits 3:0. `reg_wr` (write) or `reg_rd` (read) is high for one cycle, in the second cycle after the transfer-start cycle. `ack_n` is low in the third cycle after the transfer-start cycle.
- R3: Write data present on `host_din` in the cycle after the transfer-start cycle is captured. It appears on `reg_wdata` and on `usr_wdata`.
- R4: With address bit 4 = 1, `usr_addr` equals address bits 3:0. `usr_read` is 1 for a read and 0 for a write. `usr_start` is high for exactly one cycle, in the second cycle after the transfer-start cycle.
- R5: For a user access, `ack_n` stays high until `usr_end` is sampled 1. `ack_n` is then low in the following cycle.
- R6: `ack_n` is low for exactly one cycle per transfer. `burst_inh_n` is low in that same cycle and high otherwise.
- R7: On a read, `host_dout` carries the read data while `ack_n` is low. `drive_en` is 1 only in the acknowledge cycle of a read, and 0 for writes and between transfers.
- R8: `usr_start` may be high while `usr_end` stays 0 for TIMEOUT cycles, counting the start cycle. In that case the bridge acknowledges in the next cycle, returns 0xFF on a read, and sets `timeout_flag`. The flag stays 1 until reset.
- R9: `host_irq_n` and `irq_pending` (= not `host_irq_n`) follow `usr_irq_n` with a two-clock delay. They are unaffected by bus transfers.
- R10: After reset, `ack_n`, `burst_inh_n` and `host_irq_n` are 1. `drive_en`, `usr_start`, `reg_wr`, `reg_rd`, `irq_pending` and `timeout_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low reset |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| host_rd | input | 1 | Direction: 1 read, 0 write |
| tstart_n | input | 1 | Active-low transfer start |
| host_addr | input | 5 | Host address; bit 4 picks user side |
| host_din | input | 8 | Write data from host |
| host_dout | output | 8 | Read data to host |
| drive_en | output | 1 | Enable for external data drivers |
| ack_n | output | 1 | Active-low transfer acknowledge |
| burst_inh_n | output | 1 | Active-low burst inhibit |
| host_irq_n | output | 1 | Active-low interrupt to host |
| reg_addr | output | 4 | Internal register index |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |
| usr_addr | output | 4 | User location index |
| usr_read | output | 1 | User direction: 1 read, 0 write |
| usr_start | output | 1 | User transaction start pulse |
| usr_end | input | 1 | User transaction complete |
| usr_wdata | output | 8 | Write data to user logic |
| usr_rdata | input | 8 | Read data from user logic |
| usr_irq_n | input | 1 | Active-low user interrupt request |
| irq_pending | output | 1 | Synchronized interrupt pending status |
| timeout_flag | output | 1 | Sticky user timeout flag |

## Verification
The assertions check on every cycle that the acknowledge never lasts two cycles and that the user start pulse is single. They also check that no acknowledge leaves a wait state without an end or an expiry, that an unselected start keeps the controller idle, that the timeout flag never clears, and that the timeout counter stays in range. Several properties can only be shown by the bench's scenarios: the exact acknowledge latency for each path and wait length, read data and driver enable during the acknowledge, write-data capture, 0xFF on expiry, and the two-clock interrupt lag that persists across transfers.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_INTERNAL,
        ST_USTART,
        ST_UWAIT,
        ST_ACK
    } hbb_state_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbb_timer.sv
module hbb_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT - 1));

    // R8: the wait counter never passes its limit
    assert_timer_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) < LIMIT));
endmodule

// File: rtl/hbb_fsm.sv
module hbb_fsm
    import hbb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              tstart_n,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    input  logic              usr_end,
    input  logic [DATA_W-1:0] usr_rdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              expired,
    output logic              timer_run,
    output logic              ack_n,
    output logic              burst_inh_n,
    output logic              drive_en,
    output logic [DATA_W-1:0] host_dout,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_flag,
    output logic              usr_start,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] wdata,
    output logic              timeout_flag
);
    hbb_state_e st, st_nx;

    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rdat_q;
    logic              tmo_q;
    logic              start;

    assign start = sel && !tstart_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (start) st_nx = ST_CAPTURE;
            ST_CAPTURE:  st_nx = addr_q[ADDR_W-1] ? ST_USTART : ST_INTERNAL;
            ST_INTERNAL: st_nx = ST_ACK;
            ST_USTART,
            ST_UWAIT:    st_nx = (usr_end || expired) ? ST_ACK : ST_UWAIT;
            ST_ACK:      st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // captured transfer fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
            wd_q   <= '0;
            rdat_q <= '0;
            tmo_q  <= 1'b0;
        end else begin
            if (st == ST_IDLE && start) begin
                addr_q <= host_addr;
                rd_q   <= host_rd;
            end
            if (st == ST_CAPTURE) wd_q <= host_din;
            if (st == ST_INTERNAL) rdat_q <= reg_rdata;
            if (st == ST_USTART || st == ST_UWAIT) begin
                if (usr_end) begin
                    rdat_q <= usr_rdata;
                end else if (expired) begin
                    rdat_q <= '1;
                    tmo_q  <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        ack_n       = 1'b1;
        burst_inh_n = 1'b1;
        drive_en    = 1'b0;
        usr_start   = 1'b0;
        reg_wr      = 1'b0;
        reg_rd      = 1'b0;
        timer_run   = 1'b0;
        unique case (st)
            ST_INTERNAL: begin
                reg_wr = !rd_q;
                reg_rd = rd_q;
            end
            ST_USTART: begin
                usr_start = 1'b1;
                timer_run = 1'b1;
            end
            ST_UWAIT: timer_run = 1'b1;
            ST_ACK: begin
                ack_n       = 1'b0;
                burst_inh_n = 1'b0;
                drive_en    = rd_q;
            end
            default: ;
        endcase
    end

    assign host_dout    = rdat_q;
    assign idx          = addr_q[IDX_W-1:0];
    assign rd_flag      = rd_q;
    assign wdata        = wd_q;
    assign timeout_flag = tmo_q;

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        usr_start |=> !usr_start);
    assert_hold_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && !usr_end && !expired) |=> ack_n);
    assert_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !sel) |=> (st == ST_IDLE));
    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> timeout_flag);
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 8,
    parameter int TIMEOUT = 256,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi,
    input  logic              host_rd,
    input  logic              tstart_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              drive_en,
    output logic              ack_n,
    output logic              burst_inh_n,
    output logic              host_irq_n,
    output logic [ADDR_W-2:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-2:0] usr_addr,
    output logic              usr_read,
    output logic              usr_start,
    input  logic              usr_end,
    output logic [DATA_W-1:0] usr_wdata,
    input  logic [DATA_W-1:0] usr_rdata,
    input  logic              usr_irq_n,
    output logic              irq_pending,
    output logic              timeout_flag
);
    localparam int IDX_W = ADDR_W - 1;

    logic             sel, expired, timer_run, rd_flag;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] wdata;
    logic             irq_s;

    assign sel = !cs_lo_n && cs_hi;

    hbb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel(sel), .tstart_n(tstart_n),
        .host_rd(host_rd), .host_addr(host_addr), .host_din(host_din),
        .usr_end(usr_end), .usr_rdata(usr_rdata), .reg_rdata(reg_rdata),
        .expired(expired), .timer_run(timer_run), .ack_n(ack_n),
        .burst_inh_n(burst_inh_n), .drive_en(drive_en), .host_dout(host_dout),
        .idx(idx), .rd_flag(rd_flag), .usr_start(usr_start),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .wdata(wdata),
        .timeout_flag(timeout_flag)
    );

    hbb_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(expired)
    );

    hbb_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .d(usr_irq_n), .q(irq_s)
    );

    assign host_irq_n  = irq_s;
    assign irq_pending = !irq_s;
    assign reg_addr    = idx;
    assign usr_addr    = idx;
    assign usr_read    = rd_flag;
    assign reg_wdata   = wdata;
    assign usr_wdata   = wdata;
endmodule

// File: tb/sim_host_bus_bridge.sv
`timescale 1ns/100ps
module sim_host_bus_bridge;
    localparam int TMO = 256;
    localparam int NV  = 8;
    // {read, addr[4:0], data[7:0], delay[3:0]}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 5'h03, 8'h5A, 4'd0},
        {1'b1, 5'h07, 8'h00, 4'd0},
        {1'b1, 5'h0F, 8'h00, 4'd0},
        {1'b0, 5'h10, 8'hC3, 4'd0},
        {1'b1, 5'h15, 8'h96, 4'd0},
        {1'b1, 5'h1F, 8'h3C, 4'd3},
        {1'b0, 5'h1A, 8'h81, 4'd5},
        {1'b0, 5'h00, 8'hFF, 4'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_lo_n = 1'b1, cs_hi = 1'b0, host_rd = 1'b0, tstart_n = 1'b1;
    logic [4:0] host_addr = '0;
    logic [7:0] host_din = '0, usr_rdata = '0, reg_rdata;
    logic usr_end = 1'b0, usr_irq_n = 1'b1;
    logic [7:0] host_dout, reg_wdata, usr_wdata;
    logic drive_en, ack_n, burst_inh_n, host_irq_n, reg_wr, reg_rd;
    logic usr_read, usr_start, irq_pending, timeout_flag;
    logic [3:0] reg_addr, usr_addr;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign reg_rdata = {4'hA, reg_addr};

    host_bus_bridge #(.TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
        .host_rd(host_rd), .tstart_n(tstart_n), .host_addr(host_addr),
        .host_din(host_din), .host_dout(host_dout), .drive_en(drive_en),
        .ack_n(ack_n), .burst_inh_n(burst_inh_n), .host_irq_n(host_irq_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .usr_addr(usr_addr),
        .usr_read(usr_read), .usr_start(usr_start), .usr_end(usr_end),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_irq_n(usr_irq_n),
        .irq_pending(irq_pending), .timeout_flag(timeout_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [4:0] a, input logic [7:0] d,
                          input int dly, input bit tmo);
        int ack_at = -1;
        int ack_cnt = 0;
        int exp_at;
        logic [7:0] exp;
        exp    = a[4] ? (tmo ? 8'hFF : d) : {4'hA, a[3:0]};
        exp_at = !a[4] ? 3 : (tmo ? 2 + TMO : 3 + dly);
        @(negedge clk);
        cs_lo_n = 0; cs_hi = 1; tstart_n = 0; host_rd = rd; host_addr = a;
        host_din = d; usr_rdata = d;
        for (int i = 1; i < TMO + 12; i++) begin
            @(negedge clk);
            if (i == 1) tstart_n = 1;
            if (i == 2) begin
                if (a[4]) begin
                    chk(usr_start && usr_addr == a[3:0] && usr_read == rd, "R4 start/addr/dir",
                        {usr_start, usr_read, usr_addr}, {1'b1, rd, a[3:0]});
                    if (!rd) chk(usr_wdata == d, "R3 user wdata", usr_wdata, d);
                end else begin
                    chk(reg_wr == !rd && reg_rd == rd && reg_addr == a[3:0] && !usr_start,
                        "R2 reg strobe", {usr_start, reg_wr, reg_rd, reg_addr}, {1'b0, !rd, rd, a[3:0]});
                    if (!rd) chk(reg_wdata == d, "R3 reg wdata", reg_wdata, d);
                end
            end
            if (i == 3 && a[4]) chk(!usr_start, "R4 start one cycle", usr_start, 0);
            usr_end = a[4] && !tmo && (i == 2 + dly);
            if (!ack_n) begin
                ack_cnt++;
                if (ack_at < 0) ack_at = i;
                chk(!burst_inh_n, "R6 burst inhibit with ack", burst_inh_n, 0);
                chk(drive_en == rd, "R7 drive enable", drive_en, rd);
                if (rd) chk(host_dout == exp, tmo ? "R8 timeout data" : "R7 read data", host_dout, exp);
            end else if (drive_en || !burst_inh_n) begin
                chk(0, "R6/R7 outputs outside ack", {drive_en, burst_inh_n}, 2'b01);
            end
            if (ack_at >= 0 && i > ack_at + 2) break;
        end
        chk(ack_at == exp_at, a[4] ? "R5 ack latency" : "R2 ack latency", ack_at, exp_at);
        chk(ack_cnt == 1, "R6 single ack", ack_cnt, 1);
        cs_lo_n = 1; cs_hi = 0; usr_end = 0;
    endtask

    task automatic unselected(input logic lo_n, input logic hi);
        bit seen = 0;
        @(negedge clk);
        cs_lo_n = lo_n; cs_hi = hi; tstart_n = 0; host_rd = 1; host_addr = 5'h11;
        @(negedge clk);
        tstart_n = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!ack_n || usr_start || reg_wr || reg_rd) seen = 1;
        end
        chk(!seen, "R1 unselected ignored", seen, 0);
        cs_lo_n = 1; cs_hi = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ack_n && burst_inh_n && host_irq_n && !drive_en && !usr_start && !reg_wr
            && !reg_rd && !irq_pending && !timeout_flag, "R10 reset state",
            {ack_n, burst_inh_n, host_irq_n, drive_en, usr_start, reg_wr, reg_rd, irq_pending, timeout_flag},
            9'b111000000);

        for (int v = 0; v < NV; v++)
            access(VEC[v][17], VEC[v][16:12], VEC[v][11:4], int'(VEC[v][3:0]), 0);

        unselected(1'b0, 1'b0);
        unselected(1'b1, 1'b1);
        unselected(1'b1, 1'b0);
        access(1'b1, 5'h06, 8'h00, 0, 0);

        // R9 interrupt path, two-clock lag
        @(negedge clk); usr_irq_n = 0;
        @(negedge clk); chk(host_irq_n, "R9 irq lag one", host_irq_n, 1);
        @(negedge clk); chk(!host_irq_n && irq_pending, "R9 irq asserted",
                            {host_irq_n, irq_pending}, 2'b01);
        access(1'b0, 5'h12, 8'h44, 1, 0);
        chk(!host_irq_n && irq_pending, "R9 irq held across transfer",
            {host_irq_n, irq_pending}, 2'b01);
        usr_irq_n = 1;
        @(negedge clk); chk(!host_irq_n, "R9 release lag one", host_irq_n, 0);
        @(negedge clk); chk(host_irq_n && !irq_pending, "R9 irq released",
                            {host_irq_n, irq_pending}, 2'b10);

        // R8 timeout
        chk(!timeout_flag, "R8 flag clear before timeout", timeout_flag, 0);
        access(1'b1, 5'h1B, 8'h27, 0, 1);
        chk(timeout_flag, "R8 flag set", timeout_flag, 1);
        access(1'b0, 5'h14, 8'h62, 0, 1);
        access(1'b1, 5'h19, 8'h71, 2, 0);
        chk(timeout_flag, "R8 flag sticky", timeout_flag, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule